// File: doc/BRIEF.md
# Program ROM Bank Mapper

This block sits between a CPU address bus and a banked program ROM. It turns each CPU address in the upper program space, and optionally in a low 8 KB window, into a physical ROM bank number. Software writes four bank registers, a mode register and an outer-bank register through a simple write port. The mode register selects how the 32 KB program space is carved up: one 32 KB bank, two 16 KB halves, or four 8 KB slots. An 8 KB variant reverses the bit order of the register value.

The outer-bank field is merged above the inner bank number in every scheme, so that one large ROM can hold several independent images. The bank number is given in units of the active granularity: 32 KB, 16 KB or 8 KB units in the upper space, and always 8 KB units in the window. A valid flag tells the memory side whether the address maps to ROM at all. Both outputs are registered and reflect the address presented one clock earlier.

Top module: `prg_bank_mapper`

## Requirements
- R1: Synchronous active-high reset clears all four bank registers, the mode register and the outer register, and drives `map_bank` to 0 and `map_valid` to 0. After reset an address at 0x8000 maps to bank 0 with valid 1, and 0x6000 is unmapped.
- R2: A write with `wr_en` high is decoded from the address. When address bits 15:12 equal 0x8, bits 1:0 select bank register 0 to 3. When bits 15:12 equal 0xD, bits 1:0 = 0 select the mode register and bits 1:0 = 3 select the outer register, which keeps the low 3 data bits. All other write addresses change no state.
- R3: When mode bits 2:0 are 0, or any value from 4 to 7, every address from 0x8000 to 0xFFFF maps to {00, outer[2:0], bank3[2:0]}.
- R4: When mode bits 2:0 are 1 and address bit 14 is 0, the bank is {0, outer, bank1[3:0]}. When bit 14 is 1, the bank is {0, outer, 4'hF}.
- R5: When mode bits 2:0 are 2, address bits 14:13 choose a slot. Slots 0, 1 and 2 map to {outer, bankN[4:0]} using bank register 0, 1 or 2. Slot 3 maps to {outer, 5'h1F}.
- R6: When mode bits 2:0 are 3, the mapping equals that of mode 2, except that every 5-bit register-derived value is bit-reversed (bit i moves to bit 4-i). The fixed slot 3 value is unchanged.
- R7: When mode bit 7 is 1, addresses from 0x6000 to 0x7FFF are mapped with valid 1, in 8 KB units. In the 32 KB schemes the bank is {outer[2:1], low 6 bits of (bank3*4+3)}. In mode 1 it is {outer[2:1], low 6 bits of (bank3*2+1)}. In modes 2 and 3 it is the slot value of R5 or R6 taken from bank register 3.
- R8: Addresses below 0x6000, and addresses from 0x6000 to 0x7FFF while mode bit 7 is 0, give valid 0 and bank 0.
- R9: Outputs are registered one clock after `cpu_addr`. A register write is used by a lookup presented in the cycle directly after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 16 | CPU address of the register write |
| wr_data | input | 8 | Register write data |
| cpu_addr | input | 16 | CPU address to translate |
| map_bank | output | 8 | Mapped bank number, registered |
| map_valid | output | 1 | Address maps to ROM, registered |

## Verification
A translation result is due exactly one clock after its address is driven. A register write counts from the edge on which the strobe is sampled, so a lookup driven in the next cycle must already see the new value. The driver stamps each expected item with the cycle count at which its result is due. The monitor compares only items whose stamp matches the current count, and it samples half a period after the edge that loads the output register. The write-to-lookup cases place the lookup in the cycle right after the write, which exposes any extra pipeline stage in the register path.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;

  typedef enum logic [1:0] {
    SCH_32K     = 2'd0,
    SCH_16K     = 2'd1,
    SCH_8K      = 2'd2,
    SCH_8K_REV  = 2'd3
  } scheme_e;

  // Mode values 4..7 are unsupported and fall back to the 32 KB scheme.
  function automatic scheme_e decode_scheme(input logic [2:0] sel);
    case (sel)
      3'd1:    decode_scheme = SCH_16K;
      3'd2:    decode_scheme = SCH_8K;
      3'd3:    decode_scheme = SCH_8K_REV;
      default: decode_scheme = SCH_32K;
    endcase
  endfunction

  localparam logic [3:0] BANK_REGION = 4'h8;
  localparam logic [3:0] CTRL_REGION = 4'hD;

endpackage

// File: rtl/prg_regfile.sv
module prg_regfile
  import prg_map_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int NREG    = 4,
  parameter int OUTER_W = 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [DATA_W-1:0]              wr_data,
  output logic [NREG-1:0][DATA_W-1:0]    bank_regs,
  output logic [DATA_W-1:0]              mode_q,
  output logic [OUTER_W-1:0]             outer_q
);

  localparam int IDX_W = $clog2(NREG);

  logic [3:0]       region;
  logic [IDX_W-1:0] idx;
  logic             hit_bank;
  logic             hit_mode;
  logic             hit_outer;

  assign region    = wr_addr[ADDR_W-1 -: 4];
  assign idx       = wr_addr[IDX_W-1:0];
  assign hit_bank  = wr_en && (region == BANK_REGION);
  assign hit_mode  = wr_en && (region == CTRL_REGION) && (wr_addr[1:0] == 2'd0);
  assign hit_outer = wr_en && (region == CTRL_REGION) && (wr_addr[1:0] == 2'd3);

  for (genvar g = 0; g < NREG; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)
        bank_regs[g] <= '0;
      else if (hit_bank && (idx == IDX_W'(g)))
        bank_regs[g] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      outer_q <= '0;
    end else begin
      if (hit_mode)
        mode_q <= wr_data;
      if (hit_outer)
        outer_q <= wr_data[OUTER_W-1:0];
    end
  end

  assert_mode_load_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr[ADDR_W-1 -: 4] == 4'hD && wr_addr[1:0] == 2'd0)
      |=> (mode_q == $past(wr_data)));

  assert_outer_load_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr[ADDR_W-1 -: 4] == 4'hD && wr_addr[1:0] == 2'd3)
      |=> (outer_q == $past(wr_data[OUTER_W-1:0])));

  assert_foreign_write_R2: assert property (@(posedge clk) disable iff (rst)
    (!wr_en || (wr_addr[ADDR_W-1 -: 4] != 4'h8 && wr_addr[ADDR_W-1 -: 4] != 4'hD))
      |=> ($stable(mode_q) && $stable(outer_q) && $stable(bank_regs)));

endmodule

// File: rtl/prg_bank_calc.sv
module prg_bank_calc
  import prg_map_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int NREG    = 4,
  parameter int OUTER_W = 3,
  parameter int BANK_W  = 8
) (
  input  logic [ADDR_W-1:0]            cpu_addr,
  input  logic [NREG-1:0][DATA_W-1:0]  bank_regs,
  input  logic [DATA_W-1:0]            mode_q,
  input  logic [OUTER_W-1:0]           outer_q,
  output logic [BANK_W-1:0]            bank_nx,
  output logic                         valid_nx
);

  localparam int IN8_W  = BANK_W - OUTER_W;
  localparam int IN16_W = IN8_W - 1;
  localparam int IN32_W = IN8_W - 2;
  localparam int WIN_W  = BANK_W - 2;
  localparam int WHI_W  = BANK_W - WIN_W;

  scheme_e          scheme;
  logic [2:0]       top3;
  logic             in_rom;
  logic             in_win;
  logic [1:0]       slot;
  logic [DATA_W-1:0] r_win;
  logic [IN8_W-1:0] raw8;
  logic [IN8_W-1:0] rev8;
  logic [IN8_W-1:0] win8_raw;
  logic [IN8_W-1:0] win8_rev;
  logic [WIN_W-1:0] win32;
  logic [WIN_W-1:0] win16;
  logic [BANK_W-1:0] rom_bank;
  logic [BANK_W-1:0] win_bank;

  assign scheme = decode_scheme(mode_q[2:0]);
  assign top3   = cpu_addr[ADDR_W-1 -: 3];
  assign in_rom = top3[2];
  assign in_win = (top3 == 3'b011) && mode_q[DATA_W-1];
  assign slot   = cpu_addr[ADDR_W-2 -: 2];
  assign r_win  = bank_regs[NREG-1];

  assign raw8     = (slot == 2'd3) ? '1 : bank_regs[slot][IN8_W-1:0];
  assign win8_raw = r_win[IN8_W-1:0];

  // Bit-reversed copies for the reversed 8 KB scheme
  for (genvar i = 0; i < IN8_W; i++) begin : g_rev
    assign rev8[i]     = raw8[IN8_W-1-i];
    assign win8_rev[i] = win8_raw[IN8_W-1-i];
  end

  // Window banks for the coarse schemes: reg*4+3 and reg*2+1, truncated
  assign win32 = WIN_W'({r_win, 2'b11});
  assign win16 = WIN_W'({r_win, 1'b1});

  always_comb begin
    unique case (scheme)
      SCH_16K: begin
        rom_bank = BANK_W'({outer_q, (slot[1] ? {IN16_W{1'b1}}
                                              : bank_regs[1][IN16_W-1:0])});
        win_bank = {outer_q[OUTER_W-1 -: WHI_W], win16};
      end
      SCH_8K: begin
        rom_bank = {outer_q, raw8};
        win_bank = {outer_q, win8_raw};
      end
      SCH_8K_REV: begin
        rom_bank = {outer_q, rev8};
        win_bank = {outer_q, win8_rev};
      end
      default: begin
        rom_bank = BANK_W'({outer_q, r_win[IN32_W-1:0]});
        win_bank = {outer_q[OUTER_W-1 -: WHI_W], win32};
      end
    endcase
  end

  always_comb begin
    if (in_rom) begin
      bank_nx  = rom_bank;
      valid_nx = 1'b1;
    end else if (in_win) begin
      bank_nx  = win_bank;
      valid_nx = 1'b1;
    end else begin
      bank_nx  = '0;
      valid_nx = 1'b0;
    end
  end

endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
  import prg_map_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int NREG    = 4,
  parameter int OUTER_W = 3,
  parameter int BANK_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic [BANK_W-1:0] map_bank,
  output logic              map_valid
);

  localparam int IN8_W = BANK_W - OUTER_W;

  logic [NREG-1:0][DATA_W-1:0] bank_regs;
  logic [DATA_W-1:0]           mode_q;
  logic [OUTER_W-1:0]          outer_q;
  logic [BANK_W-1:0]           bank_nx;
  logic                        valid_nx;

  prg_regfile #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREG(NREG), .OUTER_W(OUTER_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .bank_regs(bank_regs), .mode_q(mode_q), .outer_q(outer_q)
  );

  prg_bank_calc #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREG(NREG), .OUTER_W(OUTER_W), .BANK_W(BANK_W)
  ) u_calc (
    .cpu_addr(cpu_addr), .bank_regs(bank_regs), .mode_q(mode_q), .outer_q(outer_q),
    .bank_nx(bank_nx), .valid_nx(valid_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      map_bank  <= '0;
      map_valid <= 1'b0;
    end else begin
      map_bank  <= bank_nx;
      map_valid <= valid_nx;
    end
  end

  assert_unmapped_low_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(cpu_addr[ADDR_W-1 -: 3]) < 3'd3) |-> (!map_valid && map_bank == '0));

  assert_rom_mapped_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(cpu_addr[ADDR_W-1]) && !$past(rst)) |-> map_valid);

  assert_window_gate_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(cpu_addr[ADDR_W-1 -: 3] == 3'b011) && !$past(rst))
      |-> (map_valid == $past(mode_q[DATA_W-1])));

  assert_fixed_top_slot_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(cpu_addr[ADDR_W-1 -: 3] == 3'b111 && mode_q[2:1] == 2'b01) && !$past(rst))
      |-> (map_bank[IN8_W-1:0] == '1));

endmodule

// File: tb/tb_prg_bank_mapper.sv
module tb_prg_bank_mapper;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  map_bank;
  logic        map_valid;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    int         due;
    logic       v;
    logic [7:0] b;
    string      tag;
  } exp_t;

  exp_t sb[$];

  always #2.5 clk = ~clk;

  prg_bank_mapper dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cpu_addr(cpu_addr), .map_bank(map_bank), .map_valid(map_valid)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compares every item whose result is due in this cycle
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due == cyc) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (map_valid !== e.v || map_bank !== e.b) begin
        fails++;
        $display("FAIL %s: got valid=%0b bank=%02h expected valid=%0b bank=%02h",
                 e.tag, map_valid, map_bank, e.v, e.b);
      end
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic look(input logic [15:0] a, input logic v, input logic [7:0] b,
                      input string tag);
    exp_t e;
    @(negedge clk);
    cpu_addr = a;
    e.due = cyc + 1; e.v = v; e.b = b; e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    checks++;
    if (map_valid !== 1'b0 || map_bank !== 8'h00) begin
      fails++;
      $display("FAIL R1 reset outputs: got valid=%0b bank=%02h expected valid=0 bank=00",
               map_valid, map_bank);
    end
    rst = 1'b0;

    look(16'h8000, 1'b1, 8'h00, "R1 post-reset rom");
    look(16'h6000, 1'b0, 8'h00, "R1 post-reset window off");

    wr(16'h8000, 8'h16); wr(16'h8001, 8'h23); wr(16'h8002, 8'h13);
    wr(16'h8003, 8'h0D); wr(16'hD003, 8'h05);

    look(16'h8000, 1'b1, 8'h2D, "R3 32K low");
    look(16'hFFFF, 1'b1, 8'h2D, "R3 32K high");
    look(16'h6000, 1'b0, 8'h00, "R8 window disabled");
    look(16'h4020, 1'b0, 8'h00, "R8 low space");

    wr(16'hD000, 8'h80);
    look(16'h7000, 1'b1, 8'hB7, "R7 window 32K");
    look(16'h5FFF, 1'b0, 8'h00, "R8 below window");

    wr(16'hD000, 8'h81);
    look(16'h8000, 1'b1, 8'h53, "R4 16K lower");
    look(16'hBFFF, 1'b1, 8'h53, "R4 16K lower end");
    look(16'hC000, 1'b1, 8'h5F, "R4 16K fixed upper");
    look(16'h6000, 1'b1, 8'h9B, "R7 window 16K");

    wr(16'hD000, 8'h82);
    look(16'h8000, 1'b1, 8'hB6, "R5 8K slot0");
    look(16'hA000, 1'b1, 8'hA3, "R5 8K slot1");
    look(16'hC000, 1'b1, 8'hB3, "R5 8K slot2");
    look(16'hE000, 1'b1, 8'hBF, "R5 8K fixed slot3");
    look(16'h6000, 1'b1, 8'hAD, "R7 window 8K");

    wr(16'hD000, 8'h83);
    look(16'h8000, 1'b1, 8'hAD, "R6 reversed slot0");
    look(16'hA000, 1'b1, 8'hB8, "R6 reversed slot1");
    look(16'hC000, 1'b1, 8'hB9, "R6 reversed slot2");
    look(16'hE000, 1'b1, 8'hBF, "R6 reversed fixed slot3");
    look(16'h6000, 1'b1, 8'hB6, "R6 reversed window");

    wr(16'hD000, 8'h05);
    look(16'h9000, 1'b1, 8'h2D, "R3 fallback mode 5");
    look(16'h6000, 1'b0, 8'h00, "R8 window bit clear");

    wr(16'hD000, 8'h86);
    look(16'h6000, 1'b1, 8'hB7, "R7 window fallback mode 6");
    look(16'hA000, 1'b1, 8'h2D, "R3 fallback mode 6");

    wr(16'hD001, 8'h82);
    look(16'hA000, 1'b1, 8'h2D, "R2 write to unused control slot ignored");
    wr(16'h9003, 8'h07);
    look(16'h8000, 1'b1, 8'h2D, "R2 write outside bank region ignored");
    wr(16'h5003, 8'h02);
    look(16'h8000, 1'b1, 8'h2D, "R2 write in low space ignored");

    wr(16'h8FF3, 8'h02);
    look(16'hC000, 1'b1, 8'h2A, "R9 bank write seen next cycle");
    wr(16'hD003, 8'hFA);
    look(16'h8000, 1'b1, 8'h12, "R9 outer write seen next cycle");
    look(16'h6000, 1'b1, 8'h4B, "R7 window with new outer");

    repeat (4) @(negedge clk);
    if (sb.size() != 0) begin
      fails++;
      checks++;
      $display("FAIL R9 scoreboard: got %0d pending expected 0", sb.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R9 watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule